// File: doc/BRIEF.md
# Converter cycle sequencer with serial readout

This block is the digital control of a single-channel sampling converter. It runs a fixed loop: a conversion of fixed length, a sleep state that holds the finished result, and a serial readout. The readout is clocked by a host through an active-low select and a serial clock. The conversion core is a stub outside the block. It presents a result word on `result_i`, and the sequencer captures that word on the cycle its conversion timer expires.

Both host inputs pass through two-flop synchronizers into the system clock domain. Edges are detected on the synchronized copies, so each host action reaches the ports two to three system clocks later. Serial data leaves as a value on `sdo_o` and an enable on `sdo_oe_o`, which together drive a three-state pad. While the select is low and no readout is running, `sdo_o` shows status: 1 while converting (or in power-on hold) and 0 once a result is waiting.

After an asynchronous power-on reset, the block holds for `POR_CYCLES` clocks and then starts its first conversion.

Top module: `adc_cycle_seq`

## Requirements
- R1: The state order is fixed: power-on hold, then convert, sleep, readout, and back to convert. Sleep is never skipped, and readout is reached only from sleep.
- R2: A conversion lasts exactly `CONV_CYCLES` clocks and cannot be cut short by the host. With select low during a conversion, `sdo_o` stays 1 whatever the serial clock does.
- R3: The block leaves sleep for readout only when the synchronized select and serial clock are both low. With select low and the clock high, it stays in sleep and `sdo_o` reads 0.
- R4: On entering readout, `sdo_o` shows result bit 15 (the MSB). Each falling serial-clock edge then presents the next lower bit.
- R5: The 16th falling serial-clock edge ends the readout and starts a new conversion.
- R6: A rising select during readout aborts it at once and starts a new conversion.
- R7: `sdo_oe_o` is 1 exactly when the synchronized select is low. `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R8: `lp_o` is 1 in sleep while select is high. It drops when select goes low, even while the block stays in sleep.
- R9: The result is sampled from `result_i` on the last clock of a conversion and held through sleep. Changes on `result_i` at any other time do not alter the word that is shifted out.
- R10: Reset clears all state, with `sdo_oe_o`, `sdo_o` and `lp_o` at 0. After reset is released, the block holds for `POR_CYCLES` clocks before the first conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| cs_ni | input | 1 | Host select, active low, asynchronous |
| sck_i | input | 1 | Host serial clock, asynchronous |
| result_i | input | DATA_W | Result word from the conversion core stub |
| sdo_o | output | 1 | Serial data or status value for the pad |
| sdo_oe_o | output | 1 | Pad output enable |
| lp_o | output | 1 | Low-power indicator |

## Verification
A wrong state shows at the ports within three system clocks of the host action that exposes it. A stuck or early conversion moves the busy-to-ready change of `sdo_o` outside a window of two clocks. A wrong bit index or a missed falling edge corrupts the shifted word at the first bit where it differs from the expected word. A result register that loads outside the last conversion clock shows up as a word taken from the wrong `result_i` value. The bench sweeps several bit patterns through full readouts, aborts a readout after five bits, changes `result_i` during sleep, and toggles the clock during a conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_DATA  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));
  p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt_q == '0));
endmodule

// File: rtl/out_shifter.sv
module out_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic [W-1:0] data_i,
  input  logic         load_i,
  input  logic         shift_i,
  output logic         bit_o,
  output logic         last_o
);
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(W - 1);

  logic [W-1:0]     res_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        res_q <= '0;
    else if (capture_i) res_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (load_i)  idx_q <= TOP_IDX;
    else if (shift_i) idx_q <= idx_q - 1'b1;
  end

  assign bit_o  = res_q[idx_q];
  assign last_o = (idx_q == '0);

  p_idx_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (idx_q == $past(idx_q) - 1'b1));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(res_q));
  p_no_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_o);
endmodule

// File: rtl/adc_cycle_seq.sv
module adc_cycle_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 3330000,
  parameter int unsigned POR_CYCLES  = 50000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              lp_o
);
  localparam int unsigned MAX_CYC = (CONV_CYCLES > POR_CYCLES) ? CONV_CYCLES : POR_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CONV_LIM = CNT_W'(CONV_CYCLES);
  localparam logic [CNT_W-1:0] POR_LIM  = CNT_W'(POR_CYCLES);

  seq_state_e state_q, state_d;
  logic [1:0] host_s;
  logic       cs_s, sck_s, sck_d_q, sck_fall;
  logic       tmr_run, tmr_done;
  logic       go_data, capture, load, shift, sh_bit, sh_last;
  logic       status_v;
  logic [CNT_W-1:0] tmr_lim;

  sync_2ff #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni}),
    .q_o   (host_s)
  );
  assign cs_s  = host_s[0];
  assign sck_s = host_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s;
  end
  assign sck_fall = sck_d_q & ~sck_s;

  assign tmr_run = (state_q == ST_POR) || (state_q == ST_CONV);
  assign tmr_lim = (state_q == ST_POR) ? POR_LIM : CONV_LIM;

  cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tmr_run),
    .limit_i(tmr_lim),
    .done_o (tmr_done)
  );

  assign go_data = (state_q == ST_SLEEP) && !cs_s && !sck_s;
  assign capture = (state_q == ST_CONV) && tmr_done;
  assign load    = go_data;
  assign shift   = (state_q == ST_DATA) && !cs_s && sck_fall && !sh_last;

  out_shifter #(.W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .data_i   (result_i),
    .load_i   (load),
    .shift_i  (shift),
    .bit_o    (sh_bit),
    .last_o   (sh_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:   if (tmr_done) state_d = ST_CONV;
      ST_CONV:  if (tmr_done) state_d = ST_SLEEP;
      ST_SLEEP: if (go_data)  state_d = ST_DATA;
      ST_DATA: begin
        if (cs_s)                     state_d = ST_CONV;
        else if (sck_fall && sh_last) state_d = ST_CONV;
      end
      default: state_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_POR;
    else         state_q <= state_d;
  end

  // status when not shifting: busy=1, ready=0
  always_comb begin
    unique case (state_q)
      ST_DATA:  status_v = sh_bit;
      ST_SLEEP: status_v = 1'b0;
      default:  status_v = 1'b1;
    endcase
  end

  assign sdo_oe_o = ~cs_s;
  assign sdo_o    = sdo_oe_o & status_v;
  assign lp_o     = (state_q == ST_SLEEP) && cs_s;

  p_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |=> (state_q == ST_CONV || state_q == ST_SLEEP));
  p_data_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> ($past(state_q) == ST_SLEEP || $past(state_q) == ST_DATA));
  p_sleep_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && (cs_s || sck_s)) |=> (state_q == ST_SLEEP));
  p_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !cs_s && sck_fall && sh_last) |=> (state_q == ST_CONV));
  p_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && cs_s) |=> (state_q == ST_CONV));
  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);
  p_lp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_o |-> (!tmr_run && !sdo_oe_o));
endmodule

// File: tb/tb_adc_cycle_seq.sv
module tb_adc_cycle_seq;
  localparam int unsigned DW   = 16;
  localparam int unsigned CONV = 60;
  localparam int unsigned PORC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b1;
  logic [DW-1:0] res = '0;
  logic sdo, sdo_oe, lp;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  adc_cycle_seq #(.DATA_W(DW), .CONV_CYCLES(CONV), .POR_CYCLES(PORC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck),
    .result_i(res), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .lp_o(lp)
  );

  function automatic logic [DW-1:0] pat(input int j);
    return DW'(j * 16'h1357) ^ (16'h8000 >> j);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // precondition: sleep or readout, cs low. Ends in convert with sck high.
  task automatic xfer(input int nbits, input logic [DW-1:0] exp,
                      input logic [DW-1:0] nxt, output int el);
    el = 0;
    sck = 1'b0; tick(4);
    for (int i = 0; i < nbits; i++) begin
      if (i > 0) begin sck = 1'b1; tick(3); sck = 1'b0; tick(4); end
      chk(sdo === exp[DW-1-i], $sformatf("R4 bit%0d", DW-1-i), int'(sdo), int'(exp[DW-1-i]));
    end
    if (nbits == DW) begin
      sck = 1'b1; tick(3); sck = 1'b0; tick(4);
      el = 4;
      chk(sdo === 1'b1, "R5 busy after 16th fall", int'(sdo), 1);
      res = nxt;
      sck = 1'b1;
    end else begin
      cs_n = 1'b1; tick(4);
      chk(sdo_oe === 1'b0 && sdo === 1'b0, "R7 released on abort", int'({sdo_oe, sdo}), 0);
      res = nxt;
      sck = 1'b1; cs_n = 1'b0; tick(4);
      chk(sdo === 1'b1, "R6 abort starts conversion", int'(sdo), 1);
    end
  endtask

  task automatic wait_ready(input int el0, input bit check_len);
    int el = el0;
    while (sdo !== 1'b0 && el < 10 * CONV) begin tick(1); el++; end
    if (check_len)
      chk(el >= CONV + 2 && el <= CONV + 4, "R2 conversion length", el, CONV + 3);
  endtask

  initial begin
    int el;
    res = pat(0);
    tick(5);
    chk(sdo_oe === 1'b0 && sdo === 1'b0 && lp === 1'b0, "R10 reset outputs",
        int'({sdo_oe, sdo, lp}), 0);
    cs_n = 1'b0; sck = 1'b1;
    rst_n = 1'b1;
    el = 0;
    tick(4); el += 4;
    chk(sdo_oe === 1'b1 && sdo === 1'b1, "R7 enable and R10 busy", int'({sdo_oe, sdo}), 3);
    while (sdo !== 1'b0 && el < 10 * CONV) begin tick(1); el++; end
    chk(el >= PORC + CONV - 1 && el <= PORC + CONV + 1, "R10 hold then R1 first conversion",
        el, PORC + CONV);
    // sweep patterns through full readouts
    for (int j = 0; j < 8; j++) begin
      tick(20);
      chk(sdo === 1'b0, "R3 stays in sleep with sck high", int'(sdo), 0);
      xfer(DW, pat(j), pat(j + 1), el);
      wait_ready(el, 1'b1);
    end
    // abort after 5 bits, then low power and held result
    xfer(5, pat(8), 16'h3c5a, el);
    cs_n = 1'b1;
    tick(CONV + 10);
    chk(lp === 1'b1 && sdo_oe === 1'b0 && sdo === 1'b0, "R8 low power in sleep",
        int'({lp, sdo_oe, sdo}), 4);
    res = 16'hdead;
    sck = 1'b0; tick(10);
    chk(lp === 1'b1, "R3 cs high blocks readout", int'(lp), 1);
    sck = 1'b1; cs_n = 1'b0; tick(4);
    chk(lp === 1'b0 && sdo_oe === 1'b1 && sdo === 1'b0, "R8 normal power in sleep",
        int'({lp, sdo_oe, sdo}), 2);
    xfer(DW, 16'h3c5a, 16'h9e21, el);   // R9 held value, not 16'hdead
    // sck activity during conversion must not start a readout
    for (int k = 0; k < 3; k++) begin
      sck = 1'b0; tick(4);
      chk(sdo === 1'b1, "R2 no readout in convert", int'(sdo), 1);
      sck = 1'b1; tick(4);
      chk(sdo === 1'b1, "R2 busy in convert", int'(sdo), 1);
    end
    sck = 1'b0;
    tick(CONV);
    chk(sdo === 1'b1, "R4 readout entered with MSB", int'(sdo), 1);
    xfer(DW, 16'h9e21, 16'h0000, el);
    wait_ready(el, 1'b1);
    cs_n = 1'b1; tick(4);
    chk(sdo_oe === 1'b0 && lp === 1'b1, "R7 R8 final idle", int'({sdo_oe, lp}), 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule